// File: doc/BRIEF.md
# Eight-Bit Timer with Selectable Tick Source and Capture

This block is an 8-bit up-counter for a microcontroller peripheral bus. Software writes a control register and a data register. The control register selects the operating mode and the tick source, and it carries a self-clearing bit that restarts the count. The tick source can be one of eight ratios of a free-running divider on the system clock, either edge of an external clock pin, or the rising edge of a slow sub-clock. Some codes stop the counter.

In interval mode the counter is compared with a compare buffer. The data register does not take part in the compare. The buffer takes the data-register value only in the same write that restarts the count, so software writes the data register first and then sets the restart bit. When the count equals the buffer on a tick, the count returns to zero and a match request is raised.

In capture mode the counter runs freely and raises an overflow request when it wraps. A rising edge on the capture pin stores the current count in a capture register.

Each request has its own enable and is cleared by an acknowledge from the interrupt logic. All pins from outside the clock domain pass through two synchronizer stages before edge detection.

Top module: `tick_timer`

## Requirements
- R1: After reset, ctrl_rd, count_o and cap_o read 0x00, and both interrupt outputs are low.
- R2: ctrl_rd returns bit 5 (mode) and bits 3..0 (source code) as last written. Bits 7, 6 and 4 always read 0.
- R3: A control write with bit 4 set zeroes the count at the next edge and copies the data register into the compare buffer, even if a tick occurs in that cycle. A control write with bit 4 clear changes neither the count nor the buffer.
- R4: Source codes 8 to 15 give one tick every 2, 4, 8, 16, 32, 128, 512 and 2048 system cycles respectively. The ticks come from a divider that counts from 0 after reset and fires when its low bits are all ones.
- R5: Code 5 counts rising edges of ext_clk and code 6 counts falling edges. Code 7 counts rising edges of sub_clk. Each edge reaches the count three clock edges after the pin changes.
- R6: Codes 0 to 4 hold the count unchanged whatever the pins do.
- R7: In interval mode (bit 5 = 0), a tick that finds the count equal to the compare buffer sets the count to 0 and raises the match request. Any other tick increments the count. A data-register write alone does not change the period.
- R8: In capture mode (bit 5 = 1), every tick increments the count modulo 256. A tick at 0xFF raises the overflow request. No match request is raised in this mode.
- R9: In capture mode, a synchronized rising edge of cap_in stores the count that was present before that edge into cap_o. In interval mode cap_o holds its value.
- R10: match_irq is the match request ANDed with match_ie, and ovf_irq is the overflow request ANDed with ovf_ie. An acknowledge clears its request at the next edge. If a new request arrives in the same cycle as the acknowledge, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_data | input | 1 | Write strobe for the data register |
| wdata | input | 8 | Write data bus |
| ext_clk | input | 1 | Asynchronous external count clock |
| sub_clk | input | 1 | Asynchronous slow sub-clock |
| cap_in | input | 1 | Asynchronous capture trigger |
| match_ie | input | 1 | Match interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| match_ack | input | 1 | Clears the match request |
| ovf_ack | input | 1 | Clears the overflow request |
| ctrl_rd | output | 8 | Control register readback |
| count_o | output | 8 | Current count |
| cap_o | output | 8 | Captured count |
| match_irq | output | 1 | Gated match request |
| ovf_irq | output | 1 | Gated overflow request |

## Verification
The assertions assume that ext_clk, sub_clk and cap_in each stay at one level for at least one clock. Under that assumption the edge detector never reports two edges in consecutive cycles. The stimulus toggles every pin at intervals of several cycles.

The assertions also assume that a restart write does not share a cycle with a data-register write. The bench keeps the two writes in separate cycles and always writes the data register first. Acknowledges are held high across long stretches, so that a set and a clear in the same cycle occur while the outputs are being compared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned TMR_W  = 8;
    localparam int unsigned SEL_W  = 4;
    localparam int unsigned N_TAPS = 8;

    localparam logic [SEL_W-1:0] SEL_EXT_RISE = 4'h5;
    localparam logic [SEL_W-1:0] SEL_EXT_FALL = 4'h6;
    localparam logic [SEL_W-1:0] SEL_SUB      = 4'h7;

    typedef struct packed {
        logic [TMR_W-1:0] count;
        logic [TMR_W-1:0] cmp_buf;
        logic [TMR_W-1:0] data;
        logic             mode;
        logic [SEL_W-1:0] csel;
        logic [TMR_W-1:0] cap;
        logic             mflag;
        logic             oflag;
    } tmr_state_t;

    // log2 of the division ratio for each prescaler tap
    function automatic int unsigned tap_bits(input int unsigned idx);
        case (idx)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 5;
            5: return 7;
            6: return 9;
            default: return 11;
        endcase
    endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int unsigned SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

    AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned DIV_W  = 11,
    parameter int unsigned N_TAPS = tmr_pkg::N_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_TAPS-1:0] taps
);
    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int unsigned K = tmr_pkg::tap_bits(i);
        localparam logic [DIV_W-1:0] MASK = (DIV_W'(1) << K) - 1'b1;
        assign taps[i] = ((div_q & MASK) == MASK);

        AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            taps[i] |=> !taps[i]); // R4
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int unsigned DIV_W       = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       wr_data,
    input  logic [7:0] wdata,
    input  logic       ext_clk,
    input  logic       sub_clk,
    input  logic       cap_in,
    input  logic       match_ie,
    input  logic       ovf_ie,
    input  logic       match_ack,
    input  logic       ovf_ack,
    output logic [7:0] ctrl_rd,
    output logic [7:0] count_o,
    output logic [7:0] cap_o,
    output logic       match_irq,
    output logic       ovf_irq
);
    import tmr_pkg::*;

    localparam logic [TMR_W-1:0] TOP = '1;

    tmr_state_t q, d;
    logic [N_TAPS-1:0] taps;
    logic ext_rise, ext_fall, sub_rise, sub_fall_nc, cap_rise, cap_fall_nc;
    logic tick, clr_req, m_set, o_set;

    tmr_prescaler #(.DIV_W(DIV_W), .N_TAPS(N_TAPS)) u_pre (
        .clk(clk), .rst_n(rst_n), .taps(taps)
    );
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(ext_rise), .fall(ext_fall)
    );
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sub (
        .clk(clk), .rst_n(rst_n), .pin(sub_clk), .rise(sub_rise), .fall(sub_fall_nc)
    );
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(cap_rise), .fall(cap_fall_nc)
    );

    always_comb begin
        case (q.csel)
            SEL_EXT_RISE: tick = ext_rise;
            SEL_EXT_FALL: tick = ext_fall;
            SEL_SUB:      tick = sub_rise;
            default:      tick = q.csel[3] ? taps[q.csel[2:0]] : 1'b0;
        endcase
    end

    always_comb begin
        d       = q;
        m_set   = 1'b0;
        o_set   = 1'b0;
        clr_req = wr_ctrl & wdata[4];

        if (tick) begin
            if (!q.mode) begin
                if (q.count == q.cmp_buf) begin
                    d.count = '0;
                    m_set   = 1'b1;
                end else begin
                    d.count = q.count + 1'b1;
                end
            end else begin
                o_set   = (q.count == TOP);
                d.count = q.count + 1'b1;
            end
        end

        if (q.mode && cap_rise) d.cap = q.count;

        if (wr_ctrl) begin
            d.mode = wdata[5];
            d.csel = wdata[3:0];
            if (wdata[4]) begin
                d.count   = '0;
                d.cmp_buf = q.data;
            end
        end

        if (wr_data) d.data = wdata;

        d.mflag = m_set | (q.mflag & ~match_ack);
        d.oflag = o_set | (q.oflag & ~ovf_ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_rd   = {2'b00, q.mode, 1'b0, q.csel};
    assign count_o   = q.count;
    assign cap_o     = q.cap;
    assign match_irq = q.mflag & match_ie;
    assign ovf_irq   = q.oflag & ovf_ie;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[4]) |=> (count_o == '0)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.csel < 4'h5 && !clr_req) |=> $stable(count_o)); // R6
    AST_INTERVAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.mode && tick && q.count == q.cmp_buf && !clr_req) |=> (count_o == '0 && q.mflag)); // R7
    AST_MATCH_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.mflag) |-> $past(!q.mode)); // R8
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode && tick && q.count == TOP) |=> q.oflag); // R8
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.mode && cap_rise) |=> $stable(cap_o)); // R9
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ack && !m_set) |=> !q.mflag); // R10
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_ctrl = 0, wr_data = 0;
    logic [7:0] wdata = 0;
    logic ext_clk = 0, sub_clk = 0, cap_in = 0;
    logic match_ie = 0, ovf_ie = 0, match_ack = 0, ovf_ack = 0;
    logic [7:0] ctrl_rd, count_o, cap_o;
    logic match_irq, ovf_irq;

    always #4 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data), .wdata(wdata),
        .ext_clk(ext_clk), .sub_clk(sub_clk), .cap_in(cap_in),
        .match_ie(match_ie), .ovf_ie(ovf_ie), .match_ack(match_ack), .ovf_ack(ovf_ack),
        .ctrl_rd(ctrl_rd), .count_o(count_o), .cap_o(cap_o),
        .match_irq(match_irq), .ovf_irq(ovf_irq)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string phase = "R1";

    // behavioural reference state
    int m_count, m_buf, m_data, m_mode, m_cs, m_cap, m_mf, m_of;
    longint cyc;
    bit ext_h[$], sub_h[$], cap_h[$];

    function automatic void check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic void model_reset();
        m_count = 0; m_buf = 0; m_data = 0; m_mode = 0; m_cs = 0;
        m_cap = 0; m_mf = 0; m_of = 0; cyc = 0;
        ext_h = '{0, 0, 0, 0}; sub_h = '{0, 0, 0, 0}; cap_h = '{0, 0, 0, 0};
    endfunction

    function automatic void model_update();
        int ratio, tk, mset, oset, nc, ncap;
        bit er, ef, sr, cr;
        if (!rst_n) begin model_reset(); return; end
        ext_h.push_front(ext_clk); sub_h.push_front(sub_clk); cap_h.push_front(cap_in);
        er = ext_h[2] && !ext_h[3];
        ef = !ext_h[2] && ext_h[3];
        sr = sub_h[2] && !sub_h[3];
        cr = cap_h[2] && !cap_h[3];
        void'(ext_h.pop_back()); void'(sub_h.pop_back()); void'(cap_h.pop_back());
        tk = 0;
        if (m_cs == 5) tk = er;
        else if (m_cs == 6) tk = ef;
        else if (m_cs == 7) tk = sr;
        else if (m_cs >= 8) begin
            case (m_cs)
                8: ratio = 2;    9: ratio = 4;    10: ratio = 8;   11: ratio = 16;
                12: ratio = 32;  13: ratio = 128; 14: ratio = 512; default: ratio = 2048;
            endcase
            tk = ((cyc % ratio) == ratio - 1);
        end
        nc = m_count; ncap = m_cap; mset = 0; oset = 0;
        if (tk) begin
            if (m_mode == 0) begin
                if (m_count == m_buf) begin nc = 0; mset = 1; end
                else nc = m_count + 1;
            end else begin
                oset = (m_count == 255);
                nc = (m_count + 1) % 256;
            end
        end
        if (m_mode == 1 && cr) ncap = m_count;
        if (wr_ctrl) begin
            m_mode = wdata[5];
            m_cs = wdata[3:0];
            if (wdata[4]) begin nc = 0; m_buf = m_data; end
        end
        if (wr_data) m_data = wdata;
        m_count = nc; m_cap = ncap;
        m_mf = mset || (m_mf && !match_ack);
        m_of = oset || (m_of && !ovf_ack);
        cyc++;
    endfunction

    task automatic compare_all();
        check(phase, "count", count_o, m_count);
        check("R9", "cap", cap_o, m_cap);
        check("R2", "ctrl", ctrl_rd, {m_mode[0] ? 8'h20 : 8'h00} | m_cs);
        check("R10", "match_irq", match_irq, m_mf && match_ie);
        check("R10", "ovf_irq", ovf_irq, m_of && ovf_ie);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_update();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wr_ctl(logic [7:0] v);
        wr_ctrl = 1; wdata = v; step(); wr_ctrl = 0;
    endtask

    task automatic wr_dat(logic [7:0] v);
        wr_data = 1; wdata = v; step(); wr_data = 0;
    endtask

    task automatic toggle_run(int which, int n, int gap);
        for (int i = 0; i < n; i++) begin
            if (which == 0) ext_clk = ~ext_clk;
            else if (which == 1) sub_clk = ~sub_clk;
            else cap_in = ~cap_in;
            step(gap);
        end
    endtask

    initial begin
        model_reset();
        step(3);
        rst_n = 1;
        // R1 reset state
        check("R1", "ctrl after reset", ctrl_rd, 0);
        check("R1", "count after reset", count_o, 0);
        check("R1", "cap after reset", cap_o, 0);
        check("R1", "irqs after reset", {match_irq, ovf_irq}, 0);
        match_ie = 1; ovf_ie = 1;

        // R2 readback: unused and self-clearing bits read 0
        phase = "R2";
        wr_ctl(8'hFF);
        check("R2", "ctrl readback of 0xFF", ctrl_rd, 8'h2F);
        wr_ctl(8'h00);
        check("R2", "ctrl readback of 0x00", ctrl_rd, 8'h00);

        // R7 interval with buffer 5, fast ticks
        phase = "R7";
        wr_dat(8'd5);
        wr_ctl(8'h18);
        step(40);
        match_ack = 1; step(30); match_ack = 0;
        // data write alone leaves period unchanged (R7)
        wr_dat(8'd9);
        step(40);
        check("R7", "match pending after period", match_irq, 1);
        // R3 clear loads buffer, write without clear keeps count
        phase = "R3";
        wr_ctl(8'h18);
        check("R3", "count zero after clear", count_o, 0);
        step(7);
        wr_ctl(8'h08);
        step(50);
        match_ack = 1; step(3); match_ack = 0;

        // R4 each prescaler ratio
        phase = "R4";
        wr_dat(8'hFF);
        for (int c = 8; c < 16; c++) begin
            wr_ctl(8'h10 | c[7:0]);
            step(c == 15 ? 4200 : (c >= 13 ? 1100 : 70));
        end

        // R5 external and sub-clock edges
        phase = "R5";
        wr_ctl(8'h15); toggle_run(0, 20, 3);
        wr_ctl(8'h16); toggle_run(0, 20, 4);
        wr_ctl(8'h17); toggle_run(1, 20, 5);

        // R6 stop and unavailable codes hold
        phase = "R6";
        for (int c = 0; c < 5; c++) begin
            wr_ctl(8'h05); toggle_run(0, 6, 3);
            wr_ctl(c[7:0]);
            check("R6", "ctrl holds stop code", ctrl_rd, c);
            toggle_run(0, 8, 3);
            toggle_run(1, 8, 3);
        end

        // R8 and R9 capture mode
        phase = "R8";
        wr_ctl(8'h38);
        for (int i = 0; i < 30; i++) begin
            cap_in = ~cap_in;
            step(41);
        end
        check("R8", "overflow pending", ovf_irq, 1);
        ovf_ack = 1; step(600); ovf_ack = 0;
        match_ack = 1; step(2); match_ack = 0;
        step(5);
        check("R8", "no match in capture mode", match_irq, 0);
        // R9 interval mode holds capture register
        phase = "R9";
        wr_ctl(8'h08);
        toggle_run(2, 10, 6);
        ovf_ie = 0; match_ie = 0; step(5);
        check("R10", "gated irqs low", {match_irq, ovf_irq}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule